// File: doc/BRIEF.md
# 100BASE-TX Receive End-of-Stream Detector

This block sits behind the descrambler and symbol aligner of a 100 Mb/s twisted-pair receiver. It takes one aligned 5-bit code group per clock. It turns data code groups into receive nibbles and watches every pair of adjacent code groups for the way the frame ends. A start strobe from the start-of-stream logic opens a frame. From then on, each code group is held for one clock in a single-stage delay line. This lets the block see the next code group before it commits the held one to the nibble output.

Two endings are handled. A /T/ followed by /R/ is a clean close: neither symbol is delivered as data, and the nibble interface returns to idle. Two idles in a row are an abnormal cut: the slot of the first idle is delivered as one error nibble, then carrier and data-valid drop, and a sticky status bit records the bad delimiter until a read strobe clears it. A data-position code group that is not one of the 16 data symbols is passed as an error nibble inside the frame.

The controller has three states. ST_IDLE waits for the start strobe (transition IDLE->STREAM). ST_STREAM delivers nibbles and goes back to ST_IDLE on a /T/R/ pair (STREAM->IDLE) or to ST_ABORT on an /I/I/ pair (STREAM->ABORT). ST_ABORT lasts one clock and always returns to ST_IDLE (ABORT->IDLE).

Top module: `rx_eos_detector`

## Requirements
- R1: After reset, crs, rx_dv, rx_er and bad_esd are 0 and rxd is 0.
- R2: A start strobe seen in idle raises crs on the next clock while rx_dv stays 0. The first nibble appears one clock later. rx_dv is never high while crs is low.
- R3: In a frame, each data code group comes out one clock after the following code group is taken in, with rx_dv=1 and rx_er=0. The code table (nibble:code) is 0:11110 1:01001 2:10100 3:10101 4:01010 5:01011 6:01110 7:01111 8:10010 9:10011 A:10110 B:10111 C:11010 D:11011 E:11100 F:11101.
- R4: /T/=01101 followed by /R/=00111 ends the frame. Neither symbol is delivered with rx_dv. On the clock after /R/ is taken in, crs, rx_dv and rx_er are 0 and rxd is 0.
- R5: /I/=11111 followed by /I/ ends the frame prematurely. The first /I/ slot is delivered as one nibble with rx_dv=1, rx_er=1 and rxd=ERR_FILL. On the next clock crs, rx_dv and rx_er are 0.
- R6: A premature end sets bad_esd on the clock that carries the error nibble. bad_esd then stays set until cleared.
- R7: A status_rd pulse clears bad_esd on the next clock. If status_rd and a premature end fall on the same clock, bad_esd stays set.
- R8: A data-position code group that is not in the R3 table (including a lone /T/ or lone /I/) comes out as rx_dv=1, rx_er=1, rxd=ERR_FILL. The frame continues.
- R9: A start strobe during a frame has no effect on the nibble stream.
- R10: In idle, any code group, including /T/, /R/ or /I/, leaves crs, rx_dv and rx_er at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Code-group clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cg_in | input | 5 | Aligned, descrambled code group, one per clock |
| sof_strobe | input | 1 | Marks cg_in as the first data code group of a frame |
| status_rd | input | 1 | Clear-on-read strobe for bad_esd |
| rxd | output | 4 | Receive nibble |
| rx_dv | output | 1 | Receive data valid |
| rx_er | output | 1 | Receive error for the current nibble |
| crs | output | 1 | Carrier sense |
| bad_esd | output | 1 | Sticky bad-delimiter status |

## Verification
The bench builds the block with ERR_FILL=4'h5 instead of the default 0. This makes an error nibble distinguishable from a correctly decoded data nibble 0, so a wrong substitution value cannot hide behind a valid zero nibble. The stimulus covers:
- a full sweep of all sixteen data code groups;
- an invalid group and a repeated start strobe inside a frame;
- a lone /T/ that is not followed by /R/;
- a premature cut whose clear-on-read strobe lands on the same clock, which exercises the set-wins case.

// File: rtl/rx_eos_pkg.sv
package rx_eos_pkg;

    localparam int CG_W     = 5;
    localparam int NIB_W    = 4;
    localparam int NUM_DATA = 1 << NIB_W;

    localparam logic [CG_W-1:0] CG_T = 5'b01101;
    localparam logic [CG_W-1:0] CG_R = 5'b00111;
    localparam logic [CG_W-1:0] CG_I = 5'b11111;

    typedef enum logic [1:0] {
        PAIR_DATA,
        PAIR_END,
        PAIR_CUT
    } pair_kind_t;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_STREAM,
        ST_ABORT
    } rx_state_t;

    function automatic logic [CG_W-1:0] nib_to_cg(input logic [NIB_W-1:0] n);
        logic [CG_W-1:0] c;
        unique case (n)
            4'h0: c = 5'b11110;
            4'h1: c = 5'b01001;
            4'h2: c = 5'b10100;
            4'h3: c = 5'b10101;
            4'h4: c = 5'b01010;
            4'h5: c = 5'b01011;
            4'h6: c = 5'b01110;
            4'h7: c = 5'b01111;
            4'h8: c = 5'b10010;
            4'h9: c = 5'b10011;
            4'hA: c = 5'b10110;
            4'hB: c = 5'b10111;
            4'hC: c = 5'b11010;
            4'hD: c = 5'b11011;
            4'hE: c = 5'b11100;
            default: c = 5'b11101;
        endcase
        return c;
    endfunction

endpackage

// File: rtl/rx_eos_sym_decode.sv
module rx_eos_sym_decode
    import rx_eos_pkg::*;
(
    input  logic [CG_W-1:0]  cg,
    output logic [NIB_W-1:0] nib,
    output logic             is_data
);
    // Search every data code; at most one matches.
    always_comb begin
        nib     = '0;
        is_data = 1'b0;
        for (int k = 0; k < NUM_DATA; k++) begin
            if (cg == nib_to_cg(NIB_W'(k))) begin
                nib     = NIB_W'(k);
                is_data = 1'b1;
            end
        end
    end
endmodule

// File: rtl/rx_eos_pair_classify.sv
module rx_eos_pair_classify
    import rx_eos_pkg::*;
(
    input  logic [CG_W-1:0] held_cg,
    input  logic [CG_W-1:0] next_cg,
    output pair_kind_t      kind
);
    always_comb begin
        if (held_cg == CG_T && next_cg == CG_R)
            kind = PAIR_END;
        else if (held_cg == CG_I && next_cg == CG_I)
            kind = PAIR_CUT;
        else
            kind = PAIR_DATA;
    end
endmodule

// File: rtl/rx_eos_detector.sv
module rx_eos_detector
    import rx_eos_pkg::*;
#(
    parameter logic [NIB_W-1:0] ERR_FILL = '0
)(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CG_W-1:0]  cg_in,
    input  logic             sof_strobe,
    input  logic             status_rd,
    output logic [NIB_W-1:0] rxd,
    output logic             rx_dv,
    output logic             rx_er,
    output logic             crs,
    output logic             bad_esd
);
    rx_state_t        state_q, state_d;
    logic [CG_W-1:0]  held_q;
    logic [NIB_W-1:0] held_nib;
    logic             held_is_data;
    pair_kind_t       pair;
    logic             cut_now;

    // One-group delay line: the held group is judged with the next one.
    always_ff @(posedge clk) begin
        if (!rst_n) held_q <= CG_I;
        else        held_q <= cg_in;
    end

    rx_eos_sym_decode u_dec (
        .cg      (held_q),
        .nib     (held_nib),
        .is_data (held_is_data)
    );

    rx_eos_pair_classify u_pair (
        .held_cg (held_q),
        .next_cg (cg_in),
        .kind    (pair)
    );

    assign cut_now = (state_q == ST_STREAM) && (pair == PAIR_CUT);

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (sof_strobe) state_d = ST_STREAM;
            ST_STREAM: begin
                unique case (pair)
                    PAIR_END:  state_d = ST_IDLE;
                    PAIR_CUT:  state_d = ST_ABORT;
                    default:   state_d = ST_STREAM;
                endcase
            end
            default:   state_d = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Registered nibble interface
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rxd   <= '0;
            rx_dv <= 1'b0;
            rx_er <= 1'b0;
            crs   <= 1'b0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    rxd   <= '0;
                    rx_dv <= 1'b0;
                    rx_er <= 1'b0;
                    crs   <= sof_strobe;
                end
                ST_STREAM: begin
                    unique case (pair)
                        PAIR_END: begin
                            rxd   <= '0;
                            rx_dv <= 1'b0;
                            rx_er <= 1'b0;
                            crs   <= 1'b0;
                        end
                        PAIR_CUT: begin
                            rxd   <= ERR_FILL;
                            rx_dv <= 1'b1;
                            rx_er <= 1'b1;
                            crs   <= 1'b1;
                        end
                        default: begin
                            rxd   <= held_is_data ? held_nib : ERR_FILL;
                            rx_dv <= 1'b1;
                            rx_er <= !held_is_data;
                            crs   <= 1'b1;
                        end
                    endcase
                end
                default: begin
                    rxd   <= '0;
                    rx_dv <= 1'b0;
                    rx_er <= 1'b0;
                    crs   <= 1'b0;
                end
            endcase
        end
    end

    // Sticky bad-delimiter status; a new cut wins over a read.
    always_ff @(posedge clk) begin
        if (!rst_n) bad_esd <= 1'b0;
        else        bad_esd <= (bad_esd && !status_rd) || cut_now;
    end
endmodule

// File: rtl/rx_eos_detector_chk.sv
module rx_eos_detector_chk (
    input logic clk,
    input logic rst_n,
    input logic status_rd,
    input logic rx_dv,
    input logic rx_er,
    input logic crs,
    input logic bad_esd
);
    p_dv_within_crs_r2: assert property (@(posedge clk) disable iff (!rst_n)
        rx_dv |-> crs);

    p_crs_leads_dv_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(crs) |-> !rx_dv);

    p_er_with_dv_r8: assert property (@(posedge clk) disable iff (!rst_n)
        rx_er |-> rx_dv);

    p_cut_error_nibble_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bad_esd) |-> (rx_er && rx_dv));

    p_cut_then_drop_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bad_esd) |=> (!rx_dv && !crs));

    p_bad_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (bad_esd && !status_rd) |=> bad_esd);

    p_bad_clear_by_read_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(bad_esd) |-> $past(status_rd));
endmodule

bind rx_eos_detector rx_eos_detector_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .status_rd (status_rd),
    .rx_dv     (rx_dv),
    .rx_er     (rx_er),
    .crs       (crs),
    .bad_esd   (bad_esd)
);

// File: tb/rx_eos_detector_test.sv
module rx_eos_detector_test;
    localparam logic [3:0] FILL = 4'h5;
    localparam logic [4:0] T_CG = 5'b01101;
    localparam logic [4:0] R_CG = 5'b00111;
    localparam logic [4:0] I_CG = 5'b11111;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [4:0] cg_in = 5'b11111;
    logic       sof_strobe = 1'b0;
    logic       status_rd = 1'b0;
    logic [3:0] rxd;
    logic       rx_dv, rx_er, crs, bad_esd;

    int checks = 0;
    int failures = 0;
    bit finished = 0;

    typedef struct packed {
        logic       crs;
        logic       dv;
        logic       er;
        logic [3:0] rxd;
        logic       bad;
    } exp_t;

    exp_t  exp_q[$];
    string tag_q[$];
    bit    model_bad = 0;

    always #2 clk = ~clk;

    rx_eos_detector #(.ERR_FILL(FILL)) uut (
        .clk(clk), .rst_n(rst_n), .cg_in(cg_in), .sof_strobe(sof_strobe),
        .status_rd(status_rd), .rxd(rxd), .rx_dv(rx_dv), .rx_er(rx_er),
        .crs(crs), .bad_esd(bad_esd)
    );

    function automatic logic [4:0] enc(input logic [3:0] n);
        logic [4:0] t[16] = '{5'b11110, 5'b01001, 5'b10100, 5'b10101,
                              5'b01010, 5'b01011, 5'b01110, 5'b01111,
                              5'b10010, 5'b10011, 5'b10110, 5'b10111,
                              5'b11010, 5'b11011, 5'b11100, 5'b11101};
        return t[n];
    endfunction

    // Driver: one code group per clock plus the expected result after that edge.
    task automatic step(input logic [4:0] s, input bit sof, input bit rd,
                        input bit e_crs, input bit e_dv, input bit e_er,
                        input logic [3:0] e_rxd, input bit cut, input string tag);
        exp_t e;
        @(negedge clk);
        cg_in = s;
        sof_strobe = sof;
        status_rd = rd;
        model_bad = (model_bad && !rd) || cut;
        e = '{crs: e_crs, dv: e_dv, er: e_er, rxd: e_rxd, bad: model_bad};
        exp_q.push_back(e);
        tag_q.push_back(tag);
    endtask

    task automatic idle(input int n, input bit rd, input string tag);
        for (int i = 0; i < n; i++) step(I_CG, 0, rd, 0, 0, 0, 4'h0, 0, tag);
    endtask

    // bad_pos: slot replaced by bad_code (must be 1..n-1, or -1)
    task automatic frame(input logic [3:0] nib[$], input int bad_pos,
                         input logic [4:0] bad_code, input int resof_pos,
                         input bit cut, input bit rd_on_end, input string tag);
        int n = nib.size();
        step(enc(nib[0]), 1, 0, 1, 0, 0, 4'h0, 0, "R2 start");
        for (int i = 1; i <= n; i++) begin
            logic [4:0] s;
            bit prev_bad = ((i - 1) == bad_pos);
            if (i == n)             s = cut ? I_CG : T_CG;
            else if (i == bad_pos)  s = bad_code;
            else                    s = enc(nib[i]);
            step(s, (i == resof_pos), 0, 1, 1, prev_bad,
                 prev_bad ? FILL : nib[i-1], 0,
                 prev_bad ? "R8 invalid group" : tag);
        end
        if (cut) begin
            step(I_CG, 0, rd_on_end, 1, 1, 1, FILL, 1, "R5/R6 cut nibble");
            step(I_CG, 0, 0, 0, 0, 0, 4'h0, 0, "R5 drop after cut");
        end else begin
            step(R_CG, 0, rd_on_end, 0, 0, 0, 4'h0, 0, "R4 clean end");
        end
    endtask

    // Monitor / scoreboard
    always @(posedge clk) begin
        #1;
        if (exp_q.size() > 0) begin
            exp_t e = exp_q.pop_front();
            string t = tag_q.pop_front();
            exp_t a = '{crs: crs, dv: rx_dv, er: rx_er, rxd: rxd, bad: bad_esd};
            checks++;
            if (a !== e) begin
                failures++;
                $display("FAIL %s: actual crs=%b dv=%b er=%b rxd=%h bad=%b expected crs=%b dv=%b er=%b rxd=%h bad=%b",
                         t, a.crs, a.dv, a.er, a.rxd, a.bad, e.crs, e.dv, e.er, e.rxd, e.bad);
            end
        end
    end

    initial begin
        #40000;
        if (!finished) begin
            failures++;
            $display("FAIL watchdog: actual hung expected completion");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [3:0] f[$];
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        checks++;
        if ({crs, rx_dv, rx_er, bad_esd, rxd} !== 8'h00) begin
            failures++;
            $display("FAIL R1 reset: actual %b expected 00000000",
                     {crs, rx_dv, rx_er, bad_esd, rxd});
        end

        // R10: delimiter-like symbols while idle
        step(T_CG, 0, 0, 0, 0, 0, 4'h0, 0, "R10 idle T");
        step(R_CG, 0, 0, 0, 0, 0, 4'h0, 0, "R10 idle R");
        idle(2, 0, "R10 idle I");

        // R3/R4: sweep all sixteen codes, clean end
        f = {};
        for (int k = 0; k < 16; k++) f.push_back(4'(k));
        frame(f, -1, 5'b0, -1, 0, 0, "R3 data");
        idle(2, 0, "R4 after end");

        // R8, R9, R5, R6: invalid group, second strobe, premature end
        f = '{4'h3, 4'h0, 4'h9, 4'hC, 4'h7};
        frame(f, 2, 5'b00000, 3, 1, 0, "R9 data with strobe");
        idle(2, 0, "R6 sticky");

        // R7: read clears
        step(I_CG, 0, 1, 0, 0, 0, 4'h0, 0, "R7 clear");
        idle(1, 0, "R7 cleared");

        // R7: read on same clock as cut keeps the bit
        f = '{4'hA, 4'h5};
        frame(f, -1, 5'b0, -1, 1, 1, "R3 data");
        idle(1, 0, "R7 set wins");
        step(I_CG, 0, 1, 0, 0, 0, 4'h0, 0, "R7 clear again");

        // R8: lone T not followed by R is an error nibble
        f = '{4'h1, 4'h2, 4'hF, 4'h0};
        frame(f, 1, T_CG, -1, 0, 0, "R3 data");
        idle(3, 0, "R10 idle tail");

        repeat (3) @(negedge clk);
        finished = 1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule